// File: doc/BRIEF.md
# Self-Correcting Four-State Control Machine

This block is a small sequencing controller whose state register can absorb any single bit upset without losing its place. The four states are stored as 5-bit codewords that differ pairwise in at least three bit positions. Each cycle the register contents are matched against every legal codeword. A word that equals a codeword, or is one bit away from it, is taken as that state. The next state is then formed from the matched state and the request input, and the exact codeword of that next state is written back. A flipped bit is therefore masked in the cycle it is present and removed at the following clock edge.

The machine waits in its idle state until a request arrives. It then steps through three further states and returns to idle. A registered output marks the idle state, and a registered index shows which state is held. Two registered flags report errors: one for a word that was repaired, and one for a word that lies two or more bits from every codeword. In the second case the machine is forced back to idle. For verification, a mask input is XORed into the word as it is written, so that upsets can be placed on any bit of any state.

Top module: `upset_tolerant_fsm`

## Requirements
- R1: While the asynchronous active-low reset is held, and after its release until the first clock edge, the register holds 00000, `idle_out` is 1, `state_idx` is 0, and both error flags are 0.
- R2: The states with indices 0, 1, 2 and 3 are stored as codewords 00000, 11100, 01111 and 10011. Every pair of codewords differs in at least three bits, so a stored word is never within one bit of two codewords.
- R3: From state 0, a clock edge with `req` = 1 moves to state 1, and a clock edge with `req` = 0 stays in state 0.
- R4: State 1 goes to state 2, state 2 to state 3, and state 3 to state 0, each on the next clock edge and whatever the value of `req`.
- R5: A stored word that differs from a state's codeword in exactly one bit produces the same next state, `idle_out` and `state_idx` as the exact codeword. This holds for all five bits in each of the four states.
- R6: At each clock edge with `flip_mask` = 0, the exact codeword of the next state is written. After a repaired word, `corr_flag` is therefore 0 again one cycle later, unless a new flip is injected.
- R7: `idle_out` and `state_idx` are registered and update on the same edge. `idle_out` is 1 exactly when `state_idx` is 0.
- R8: `corr_flag` becomes 1 on the edge that follows a cycle in which the register held a word exactly one bit away from a codeword. Otherwise it becomes 0 on that edge.
- R9: If the register holds a word at distance two or more from every codeword, the next edge sets `fatal_flag` to 1, sets `state_idx` to 0 and `idle_out` to 1, and writes codeword 00000. `fatal_flag` is 0 after any other word.
- R10: At each clock edge, `flip_mask` is XORed bitwise into the codeword being written. A zero mask leaves the written word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Transition request, acted on in state 0 |
| flip_mask | input | 5 | Bits XORed into the word written at each edge (upset hook) |
| idle_out | output | 1 | Registered, 1 while the machine is in state 0 |
| state_idx | output | 2 | Registered index of the current state |
| corr_flag | output | 1 | Registered, a one-bit upset was repaired in the previous cycle |
| fatal_flag | output | 1 | Registered, an unrepairable word was seen in the previous cycle and the machine was forced to idle |

## Verification
Two things can happen in the same cycle. The register can hold a one-bit-damaged word, which the decoder must repair, and the next-state logic must take a real transition from that repaired state, including the request-driven move out of idle. The bench provokes this by placing the flip on the edge that writes each state, for all five bits. The next edge then has to both repair the word and advance. A behavioural model compares state index, idle output and both flags on every cycle. A second collision comes from injecting words that lie two bits from every codeword in the middle of the sequence. The forced return to idle then has to win over the normal advance.

// File: rtl/ufsm_pkg.sv
package ufsm_pkg;

   localparam int CW = 5;                  // codeword width
   localparam int NS = 4;                  // number of states
   localparam int IW = $clog2(NS);         // state index width
   localparam int MIN_DIST = 3;            // required pairwise distance

   typedef logic [CW-1:0] cw_t;
   typedef logic [IW-1:0] idx_t;

   // Codeword assigned to each state index (R2)
   function automatic cw_t code_of(int i);
      case (i)
         0:       return 5'b00000;
         1:       return 5'b11100;
         2:       return 5'b01111;
         3:       return 5'b10011;
         default: return '0;
      endcase
   endfunction

   function automatic int hdist(cw_t a, cw_t b);
      int n;
      n = 0;
      for (int k = 0; k < CW; k++) n += int'(a[k] ^ b[k]);
      return n;
   endfunction

endpackage

// File: rtl/ufsm_decoder.sv
module ufsm_decoder
   import ufsm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  cw_t  word,
   output idx_t idx,
   output logic exact,
   output logic corr,
   output logic bad
);

   logic [NS-1:0] near;
   logic [NS-1:0] same;

   // One distance matcher per legal state
   for (genvar i = 0; i < NS; i++) begin : g_match
      assign near[i] = (hdist(word, code_of(i)) <= 1);
      assign same[i] = (word == code_of(i));
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < NS; i++) begin
         if (near[i]) idx = idx | idx_t'(i);
      end
   end

   assign exact = |same;
   assign bad   = ~|near;
   assign corr  = (|near) & ~exact;

   // The codeword spacing guarantees at most one state claims a word
   assert_single_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(near));

endmodule

// File: rtl/ufsm_next.sv
module ufsm_next
   import ufsm_pkg::*;
(
   input  idx_t cur_idx,
   input  logic cur_bad,
   input  logic req,
   output idx_t nxt_idx,
   output cw_t  nxt_code
);

   always_comb begin
      if (cur_bad) begin
         nxt_idx = '0;
      end else if (cur_idx == '0) begin
         nxt_idx = req ? idx_t'(1) : '0;
      end else if (cur_idx == idx_t'(NS - 1)) begin
         nxt_idx = '0;
      end else begin
         nxt_idx = cur_idx + idx_t'(1);
      end
   end

   assign nxt_code = code_of(int'(nxt_idx));

endmodule

// File: rtl/upset_tolerant_fsm.sv
module upset_tolerant_fsm
   import ufsm_pkg::*;
#(
   parameter int STATE_W  = 5,
   parameter int N_STATES = 4
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req,
   input  logic [STATE_W-1:0]          flip_mask,
   output logic                        idle_out,
   output logic [$clog2(N_STATES)-1:0] state_idx,
   output logic                        corr_flag,
   output logic                        fatal_flag
);

   // Elaboration checks on the parameters and the code table
   if (STATE_W != CW) begin : g_bad_width
      $error("STATE_W must equal the codeword width");
   end
   if (N_STATES != NS) begin : g_bad_count
      $error("N_STATES must equal the number of encoded states");
   end
   for (genvar a = 0; a < NS; a++) begin : g_pair_a
      for (genvar b = a + 1; b < NS; b++) begin : g_pair_b
         if (hdist(code_of(a), code_of(b)) < MIN_DIST) begin : g_close
            $error("codewords too close to correct a single flip");
         end
      end
   end

   cw_t  word_q;
   idx_t dec_idx;
   logic dec_exact, dec_corr, dec_bad;
   idx_t nxt_idx;
   cw_t  nxt_code;

   ufsm_decoder u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .word  (word_q),
      .idx   (dec_idx),
      .exact (dec_exact),
      .corr  (dec_corr),
      .bad   (dec_bad)
   );

   ufsm_next u_next (
      .cur_idx  (dec_idx),
      .cur_bad  (dec_bad),
      .req      (req),
      .nxt_idx  (nxt_idx),
      .nxt_code (nxt_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q     <= code_of(0);
         state_idx  <= '0;
         idle_out   <= 1'b1;
         corr_flag  <= 1'b0;
         fatal_flag <= 1'b0;
      end else begin
         word_q     <= nxt_code ^ flip_mask;
         state_idx  <= nxt_idx;
         idle_out   <= (nxt_idx == '0);
         corr_flag  <= dec_corr;
         fatal_flag <= dec_bad;
      end
   end

   assert_idle_tracks_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
      idle_out == (state_idx == '0));

   assert_fatal_goes_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fatal_flag |-> (state_idx == '0) && idle_out);

   assert_chain_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_bad && dec_idx == idx_t'(1)) |-> nxt_idx == idx_t'(2));

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_bad && dec_idx == '0 && !req) |-> nxt_idx == '0);

   assert_scrub_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flip_mask == '0) |=> dec_exact);

endmodule

// File: tb/upset_tolerant_fsm_tb.sv
module upset_tolerant_fsm_tb;

   localparam time CYC = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0;
   logic [4:0] flip_mask = '0;
   logic       idle_out;
   logic [1:0] state_idx;
   logic       corr_flag;
   logic       fatal_flag;

   int checks = 0;
   int fails  = 0;

   // Reference model state
   logic [4:0] mw;
   int         e_idx;
   logic       e_corr, e_fatal;
   logic [4:0] tbcode [4];

   always #(CYC/2) clk = ~clk;

   upset_tolerant_fsm u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req),
      .flip_mask  (flip_mask),
      .idle_out   (idle_out),
      .state_idx  (state_idx),
      .corr_flag  (corr_flag),
      .fatal_flag (fatal_flag)
   );

   function automatic int pop5(logic [4:0] v);
      int n = 0;
      for (int k = 0; k < 5; k++) n += int'(v[k]);
      return n;
   endfunction

   // Index of the state the model's word decodes to, -1 if none
   function automatic int claim(logic [4:0] w, output int d);
      for (int k = 0; k < 4; k++) begin
         if (pop5(w ^ tbcode[k]) <= 1) begin
            d = pop5(w ^ tbcode[k]);
            return k;
         end
      end
      d = 99;
      return -1;
   endfunction

   function automatic int model_next(logic [4:0] w, logic r);
      int d, c;
      c = claim(w, d);
      if (c < 0) return 0;
      if (c == 0) return r ? 1 : 0;
      return (c + 1) % 4;
   endfunction

   task automatic compare(string tag);
      checks++;
      if (idle_out !== (e_idx == 0) || state_idx !== 2'(e_idx) ||
          corr_flag !== e_corr || fatal_flag !== e_fatal) begin
         fails++;
         $display("FAIL %s: idle=%b idx=%0d corr=%b fatal=%b expected idle=%b idx=%0d corr=%b fatal=%b",
                  tag, idle_out, state_idx, corr_flag, fatal_flag,
                  (e_idx == 0), e_idx, e_corr, e_fatal);
      end
   endtask

   // Drive at the falling edge, advance the model over one rising edge, compare at the next falling edge
   task automatic step(logic r, logic [4:0] m, string tag);
      int d, c, n;
      req = r;
      flip_mask = m;
      c = claim(mw, d);
      n = model_next(mw, r);
      e_corr  = (c >= 0) && (d == 1);
      e_fatal = (c < 0);
      e_idx   = n;
      mw      = tbcode[n] ^ m;
      @(negedge clk);
      compare(tag);
   endtask

   // From idle: run one full pass, flipping bit b on the edge that writes state s
   task automatic pass_with_flip(int s, int b, string tag);
      logic [4:0] m;
      m = 5'b00001 << b;
      step(1'b0, (s == 0) ? m : 5'b0, tag);
      step(1'b1, (s == 1) ? m : 5'b0, tag);
      step(1'b0, (s == 2) ? m : 5'b0, tag);
      step(1'b1, (s == 3) ? m : 5'b0, tag);
      step(1'b0, 5'b0, tag);
      step(1'b0, 5'b0, tag);
   endtask

   initial begin
      #(CYC * 20000);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      tbcode[0] = 5'b00000;
      tbcode[1] = 5'b11100;
      tbcode[2] = 5'b01111;
      tbcode[3] = 5'b10011;
      mw = 5'b00000;
      e_idx = 0; e_corr = 1'b0; e_fatal = 1'b0;

      // R1: reset state, then after release before any edge
      #(CYC * 2 + 2ns);
      compare("R1 reset held");
      @(negedge clk);
      rst_n = 1'b1;
      #1ns;
      compare("R1 after release");

      // R3: idle hold and request
      step(1'b0, 5'b0, "R3 hold");
      step(1'b0, 5'b0, "R3 hold");
      step(1'b1, 5'b0, "R3 request");
      // R4: chain ignores req
      step(1'b1, 5'b0, "R4 chain");
      step(1'b0, 5'b0, "R4 chain");
      step(1'b1, 5'b0, "R4 chain");
      step(1'b1, 5'b0, "R4 back to idle then request");
      step(1'b0, 5'b0, "R4 chain");
      step(1'b0, 5'b0, "R4 chain");
      step(1'b0, 5'b0, "R7 idle return");

      // R5/R8: every bit of every state
      for (int s = 0; s < 4; s++) begin
         for (int b = 0; b < 5; b++) begin
            pass_with_flip(s, b, "R5 single flip");
         end
      end

      // R6/R10: flip on request edge, then clean writes scrub it
      step(1'b1, 5'b00100, "R10 flip on request edge");
      step(1'b0, 5'b0, "R6 repaired and advanced");
      step(1'b0, 5'b0, "R6 scrubbed");
      step(1'b0, 5'b0, "R6 scrubbed");
      step(1'b0, 5'b0, "R6 idle");

      // R9: every word far from all codes, injected mid-sequence
      for (int w = 0; w < 32; w++) begin
         int d, c;
         c = claim(5'(w), d);
         if (c < 0) begin
            step(1'b1, 5'b0, "R9 setup");
            step(1'b0, 5'(w) ^ tbcode[2], "R9 inject");
            step(1'b1, 5'b0, "R9 forced idle");
            step(1'b0, 5'b0, "R9 recovered");
         end
      end

      // Mixed request pattern with flips on alternating bits
      for (int i = 0; i < 40; i++) begin
         step(1'((i * 7) % 3 == 0), (i % 3 == 1) ? (5'b00001 << (i % 5)) : 5'b0, "R5 mixed");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule